// File: doc/BRIEF.md
# Two-Channel Serial DAC Front End

This block is the digital side of a two-channel 12-bit digital-to-analog converter. A host sends 16-bit words over a three-wire serial link: an active-low frame strobe, a serial clock whose falling edges capture data, and a data line. One bit of each word picks channel A or channel B. Twelve bits carry the code, which is placed in that channel's input register.

Two 12-bit DAC latches drive the resistor ladders. Both latches always load together, in one of two ways. The first is a falling edge on the load strobe. The second applies when the load strobe is held low: the latches then update on their own as each word completes.

A clear input forces every register to a zero-output code. A format input chooses between binary coding and twos-complement coding. All serial and control pins are asynchronous to the system clock and are resynchronised inside the block.

Top module: `dual_dac_serial_front`

## Requirements
- R1: After synchronous reset both latch outputs read 0x000.
- R2: A word is 16 bits, most significant bit first, and one bit is taken on each falling `ser_clk` edge while `frame_n` is low. Bit 12 selects the channel (0 = A, 1 = B), bits 11..0 are the code, and bits 15..13 have no effect on either output.
- R3: A completed word writes only the selected channel's input register. Both latch outputs stay unchanged while `load_n` stays high.
- R4: A falling edge on `load_n` copies both input registers into both latches in the same cycle.
- R5: When `load_n` is low as a word completes, both latches load automatically. The selected channel takes the new code and the other channel takes its held input register.
- R6: If `frame_n` rises before the 16th falling edge, the word is discarded and writes nothing. The next low `frame_n` starts a fresh word.
- R7: With `twos_fmt` = 1, bit 11 of a received code is inverted before storage, so 0x000 maps to 0x800 and 0xFFF maps to 0x7FF. With `twos_fmt` = 0 the code is stored unchanged.
- R8: While `clear_n` is low, both input registers and both latches are set to 0x000 when `twos_fmt` = 0, or to 0x800 when `twos_fmt` = 1.
- R9: A low `clear_n` overrides any word write, automatic load or `load_n` edge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is captured on its falling edge |
| frame_n | input | 1 | Active-low word frame |
| ser_data | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Load strobe; a falling edge loads both latches, and a held low level selects automatic update |
| clear_n | input | 1 | Active-low clear |
| twos_fmt | input | 1 | 1 = twos-complement input coding, 0 = binary |
| code_a | output | 12 | Straight-binary latch code, channel A |
| code_b | output | 12 | Straight-binary latch code, channel B |

## Verification
The input registers are hidden. A wrong bit count, a wrong channel decode or a stale input register therefore shows up only at the next load of the latches. That load comes from a `load_n` edge, or from the end of the next word when automatic update is active. Each check is placed right after such a load, within a few system clocks of the triggering edge. Clear and format errors show on both outputs within four system clocks of the `clear_n` edge.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
    parameter int CODE_W  = 12;
    parameter int WORD_W  = 16;
    parameter int SEL_BIT = 12;

    typedef logic [CODE_W-1:0] dsf_code_t;

    typedef struct packed {
        logic      sel;
        dsf_code_t code;
    } dsf_word_t;

    function automatic dsf_code_t to_latch(dsf_code_t c, logic twos);
        dsf_code_t r;
        r = c;
        r[CODE_W-1] = c[CODE_W-1] ^ twos;
        return r;
    endfunction

    function automatic dsf_code_t clear_code(logic twos);
        dsf_code_t r;
        r = '0;
        r[CODE_W-1] = twos;
        return r;
    endfunction
endpackage

// File: rtl/dsf_sync.sv
module dsf_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/dsf_shifter.sv
module dsf_shifter
    import dsf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frame_s,
    input  logic      sclk_fall,
    input  logic      sdin_s,
    output logic      done,
    output dsf_word_t word
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (frame_s) begin
                cnt <= '0;
            end else if (sclk_fall && cnt != FULL) begin
                sh  <= {sh[WORD_W-2:0], sdin_s};
                cnt <= cnt + 1'b1;
                if (cnt == LAST) done <= 1'b1;
            end
        end
    end

    assign word.sel  = sh[SEL_BIT];
    assign word.code = sh[CODE_W-1:0];

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_short_discard_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_s && cnt != FULL) |=> !done);
endmodule

// File: rtl/dsf_latches.sv
module dsf_latches
    import dsf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      done,
    input  dsf_word_t word,
    input  logic      fmt_s,
    input  logic      load_s,
    input  logic      load_fall,
    input  logic      clr_s,
    output dsf_code_t lat_a,
    output dsf_code_t lat_b
);
    dsf_code_t in_a, in_b, nxt_a, nxt_b, new_code;
    logic      auto_ld;

    always_comb begin
        new_code = to_latch(word.code, fmt_s);
        nxt_a    = (done && !word.sel) ? new_code : in_a;
        nxt_b    = (done &&  word.sel) ? new_code : in_b;
        auto_ld  = done && !load_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_a  <= '0;
            in_b  <= '0;
            lat_a <= '0;
            lat_b <= '0;
        end else if (!clr_s) begin
            in_a  <= clear_code(fmt_s);
            in_b  <= clear_code(fmt_s);
            lat_a <= clear_code(fmt_s);
            lat_b <= clear_code(fmt_s);
        end else begin
            in_a <= nxt_a;
            in_b <= nxt_b;
            if (auto_ld) begin
                lat_a <= nxt_a;
                lat_b <= nxt_b;
            end else if (load_fall) begin
                lat_a <= in_a;
                lat_b <= in_b;
            end
        end
    end

    p_clear_code_r8: assert property (@(posedge clk) disable iff (rst)
        !clr_s |=> (lat_a == {$past(fmt_s), {(CODE_W-1){1'b0}}}) && (lat_a == lat_b));
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_s && !load_fall && !(done && !load_s)) |=> $stable(lat_a) && $stable(lat_b));
    p_auto_a_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_s && done && !load_s && !word.sel) |=> lat_a == $past(new_code));
    p_auto_b_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_s && done && !load_s && word.sel) |=> lat_b == $past(new_code));
endmodule

// File: rtl/dual_dac_serial_front.sv
module dual_dac_serial_front
    import dsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              frame_n,
    input  logic              ser_data,
    input  logic              load_n,
    input  logic              clear_n,
    input  logic              twos_fmt,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);
    localparam int NSYNC = 6;

    logic [NSYNC-1:0] raw, syn;
    logic sclk_s, frame_s, sdin_s, load_s, clr_s, fmt_s;
    logic sclk_prev, load_prev, sclk_fall, load_fall;
    logic done;
    dsf_word_t word;

    assign raw = {twos_fmt, clear_n, load_n, ser_data, frame_n, ser_clk};
    assign {fmt_s, clr_s, load_s, sdin_s, frame_s, sclk_s} = syn;

    dsf_sync #(.W(NSYNC), .RST_VAL(6'b011011)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b1;
            load_prev <= 1'b1;
        end else begin
            sclk_prev <= sclk_s;
            load_prev <= load_s;
        end
    end

    assign sclk_fall = sclk_prev && !sclk_s;
    assign load_fall = load_prev && !load_s;

    dsf_shifter u_shift (
        .clk(clk), .rst(rst), .frame_s(frame_s), .sclk_fall(sclk_fall),
        .sdin_s(sdin_s), .done(done), .word(word)
    );

    dsf_latches u_lat (
        .clk(clk), .rst(rst), .done(done), .word(word), .fmt_s(fmt_s),
        .load_s(load_s), .load_fall(load_fall), .clr_s(clr_s),
        .lat_a(code_a), .lat_b(code_b)
    );

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (code_a == '0) && (code_b == '0));
endmodule

// File: tb/dual_dac_serial_front_bench.sv
`timescale 1ns/1ps
module dual_dac_serial_front_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b1, frame_n = 1'b1, ser_data = 1'b0;
    logic load_n = 1'b1, clear_n = 1'b1, twos_fmt = 1'b0;
    logic [11:0] code_a, code_b;

    int total = 0;
    int bad = 0;
    logic [11:0] q_a[$];
    logic [11:0] q_b[$];
    string       q_tag[$];
    event        chk_ev;

    always #2.5 clk = ~clk;

    dual_dac_serial_front u_dual_dac_serial_front (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .frame_n(frame_n),
        .ser_data(ser_data), .load_n(load_n), .clear_n(clear_n),
        .twos_fmt(twos_fmt), .code_a(code_a), .code_b(code_b)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic [11:0] a, input logic [11:0] b, input string tag);
        q_a.push_back(a);
        q_b.push_back(b);
        q_tag.push_back(tag);
        -> chk_ev;
        #0;
    endtask

    initial begin : monitor
        forever begin
            @(chk_ev);
            while (q_a.size() > 0) begin
                logic [11:0] ea, eb;
                string t;
                ea = q_a.pop_front();
                eb = q_b.pop_front();
                t  = q_tag.pop_front();
                total++;
                if (code_a !== ea) begin
                    bad++;
                    $display("FAIL %s code_a actual=%03h expected=%03h", t, code_a, ea);
                end
                total++;
                if (code_b !== eb) begin
                    bad++;
                    $display("FAIL %s code_b actual=%03h expected=%03h", t, code_b, eb);
                end
            end
        end
    end

    task automatic send_word(input logic [15:0] w, input int nbits);
        frame_n = 1'b0;
        wait_clk(3);
        for (int i = 0; i < nbits; i++) begin
            ser_data = w[15-i];
            wait_clk(3);
            ser_clk = 1'b0;
            wait_clk(3);
            ser_clk = 1'b1;
        end
        wait_clk(3);
        frame_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_clk(3);
        load_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic pulse_clear();
        clear_n = 1'b0;
        wait_clk(3);
        clear_n = 1'b1;
        wait_clk(6);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : driver
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);
        expect_out(12'h000, 12'h000, "R1 reset");

        send_word(16'h0123, 16);
        expect_out(12'h000, 12'h000, "R3 word A held");
        send_word(16'h1ABC, 16);
        expect_out(12'h000, 12'h000, "R3 word B held");
        pulse_load();
        expect_out(12'h123, 12'hABC, "R4 load both");

        send_word(16'hE456, 16);
        pulse_load();
        expect_out(12'h456, 12'hABC, "R2 top bits ignored");

        send_word(16'h1FFF, 8);
        pulse_load();
        expect_out(12'h456, 12'hABC, "R6 short word discarded");
        send_word(16'h1321, 16);
        pulse_load();
        expect_out(12'h456, 12'h321, "R6 fresh word after abort");

        load_n = 1'b0;
        wait_clk(6);
        send_word(16'h07FF, 16);
        expect_out(12'h7FF, 12'h321, "R5 auto A");
        send_word(16'h1001, 16);
        expect_out(12'h7FF, 12'h001, "R5 auto B");
        send_word(16'h0001, 16);
        expect_out(12'h001, 12'h001, "R2 msb first");

        twos_fmt = 1'b1;
        wait_clk(4);
        send_word(16'h0000, 16);
        expect_out(12'h800, 12'h001, "R7 twos zero");
        send_word(16'h1FFF, 16);
        expect_out(12'h800, 12'h7FF, "R7 twos minus one");

        pulse_clear();
        expect_out(12'h800, 12'h800, "R8 clear twos");
        twos_fmt = 1'b0;
        wait_clk(4);
        pulse_clear();
        expect_out(12'h000, 12'h000, "R8 clear binary");

        load_n = 1'b1;
        wait_clk(6);
        send_word(16'h0555, 16);
        pulse_clear();
        pulse_load();
        expect_out(12'h000, 12'h000, "R8 input regs cleared");

        load_n = 1'b0;
        clear_n = 1'b0;
        wait_clk(6);
        send_word(16'h0ABC, 16);
        expect_out(12'h000, 12'h000, "R9 clear beats auto load");
        clear_n = 1'b1;
        wait_clk(6);
        expect_out(12'h000, 12'h000, "R9 no late load");

        wait_clk(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule